// File: doc/BRIEF.md
# Shared-Adder Four-Operation Arithmetic Unit

This block computes one of four results from two unsigned 4-bit operands, `a_i` and `b_i`: their sum, their difference, `a_i` plus one, or `a_i` times two. A 2-bit operation code picks the result. A single ripple-carry adder does the work for all four operations. Operand steering in front of the adder sets its two inputs and its carry-in for the chosen operation. The result is always 5 bits wide. The top bit holds the carry for add, increment and double. For subtract it holds the sign of the two's-complement difference.

By default the result goes through an output register that captures it only when `valid_i` is high. A `valid_o` strobe follows one cycle after `valid_i`, so a surrounding pipeline can check each result in the cycle it appears. Setting `REGISTER_OUT` to 0 gives a purely combinational path in which `valid_o` equals `valid_i`.

Top module: `arith4_unit`

## Requirements
- R1: With `op_i` = 2'b00, the captured result equals `a_i + b_i` as a 5-bit unsigned value. The carry out of bit 3 appears in `result_o[4]`.
- R2: With `op_i` = 2'b01, the captured result equals `a_i - b_i` reduced modulo 32, which is the 5-bit two's-complement difference. `result_o[4]` is 1 exactly when `a_i < b_i`, and a zero difference gives 5'b00000.
- R3: With `op_i` = 2'b10, the captured result equals `a_i + 1`. An operand of 4'hF gives 5'b10000.
- R4: With `op_i` = 2'b11, the captured result equals `a_i` shifted left by one place. `result_o[0]` is always 0, and `result_o[4]` equals the old `a_i[3]`.
- R5: The result is captured on a rising clock edge at which `valid_i` is high. It is visible on `result_o` from that edge until the next capture.
- R6: `valid_o` equals the value that `valid_i` had at the previous rising clock edge.
- R7: At a rising edge where `valid_i` is low, `result_o` keeps its value, whatever `a_i`, `b_i` and `op_i` are doing.
- R8: While `rst_ni` is low, `result_o` is 5'b00000 and `valid_o` is 0. Both clear at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and operation code are valid; capture the result |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 increment A, 11 double A |
| a_i | input | 4 | Operand A, unsigned |
| b_i | input | 4 | Operand B, unsigned |
| result_o | output | 5 | Registered 5-bit result |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |

## Verification
The hardest case to reach from the ports is the top bit under subtraction. There it is the inverse of the adder's carry rather than the carry itself, so it is only correct if borrow and equality are handled together. The stimulus steps through every combination of operand and operation code, which covers every A < B, A = B and A > B pair. Directed cases add the endpoints 0 − 15, 15 − 0 and 15 + 15. A separate scenario holds `valid_i` low while the operands change, to show the register keeps its value. A final scenario asserts reset mid-run, between clock edges.

// File: rtl/arith4_pkg.sv
package arith4_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_INC = 2'b10,
    OP_DBL = 2'b11
  } op_e;
endpackage

// File: rtl/arith4_steer.sv
module arith4_steer
  import arith4_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic         cin_o,
  output logic         borrow_mode_o
);
  op_e op;
  assign op = op_e'(op_i);

  always_comb begin
    x_o           = a_i;
    y_o           = b_i;
    cin_o         = 1'b0;
    borrow_mode_o = 1'b0;
    unique case (op)
      OP_ADD: ;
      OP_SUB: begin
        y_o           = ~b_i;
        cin_o         = 1'b1;
        borrow_mode_o = 1'b1;
      end
      OP_INC: begin
        y_o   = '0;
        cin_o = 1'b1;
      end
      OP_DBL: y_o = a_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/arith4_adder.sv
module arith4_adder #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p        = x_i[i] ^ y_i[i];
    assign sum_o[i] = p ^ c[i];
    assign c[i+1]   = (x_i[i] & y_i[i]) | (p & c[i]);
  end

  assign cout_o = c[W];
endmodule

// File: rtl/arith4_outreg.sv
module arith4_outreg #(
  parameter int unsigned RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [RW-1:0] d_i,
  output logic [RW-1:0] q_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) q_o <= d_i;
    end
  end

  a_r6_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r6_valid_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(q_o));
  a_r5_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> q_o == $past(d_i));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r8_reset_clear: assert (q_o == '0 && !valid_o);
    end
  end
endmodule

// File: rtl/arith4_unit.sv
module arith4_unit
  import arith4_pkg::*;
#(
  parameter int unsigned W            = 4,
  parameter bit          REGISTER_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   result_o,
  output logic         valid_o
);
  localparam int unsigned RW = W + 1;

  logic [W-1:0]  x, y, sum;
  logic          cin, cout, borrow_mode;
  logic [RW-1:0] comb_res;

  arith4_steer #(.W(W)) u_steer (
    .op_i          (op_i),
    .a_i           (a_i),
    .b_i           (b_i),
    .x_o           (x),
    .y_o           (y),
    .cin_o         (cin),
    .borrow_mode_o (borrow_mode)
  );

  arith4_adder #(.W(W)) u_adder (
    .x_i    (x),
    .y_i    (y),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  // Subtract: a missing carry out means a borrow, so the top bit becomes the sign
  assign comb_res = {cout ^ borrow_mode, sum};

  if (REGISTER_OUT) begin : g_reg
    arith4_outreg #(.RW(RW)) u_outreg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .d_i     (comb_res),
      .q_o     (result_o),
      .valid_o (valid_o)
    );

    a_r1_add_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_ADD) |=>
        result_o == RW'($past(a_i)) + RW'($past(b_i)));
    a_r2_sub_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_SUB) |=> result_o[W] == ($past(a_i) < $past(b_i)));
    a_r3_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_INC) |=> result_o == RW'($past(a_i)) + RW'(1));
    a_r4_dbl_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_DBL) |=> !result_o[0] && result_o[W] == $past(a_i[W-1]));
  end else begin : g_comb
    assign result_o = comb_res;
    assign valid_o  = valid_i;
  end
endmodule

// File: tb/tb_arith4_unit.sv
module tb_arith4_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [3:0] a_i = 4'h0;
  logic [3:0] b_i = 4'h0;
  logic [4:0] result_o;
  logic       valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  arith4_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .valid_o(valid_o)
  );

  function automatic logic [4:0] ref_res(input logic [1:0] op, input logic [3:0] a,
                                         input logic [3:0] b);
    case (op)
      2'b00:   return {1'b0, a} + {1'b0, b};
      2'b01:   return {1'b0, a} - {1'b0, b};
      2'b10:   return {1'b0, a} + 5'd1;
      default: return {a, 1'b0};
    endcase
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] op);
    case (op)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  // Drive at negedge, capture at posedge, observe at the following negedge
  task automatic apply_op(input logic [1:0] op, input logic [3:0] a, input logic [3:0] b);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; valid_i = 1'b1;
    @(negedge clk_i);
    check(req_of(op), result_o, ref_res(op, a, b));
    check("R6", {4'b0, valid_o}, 5'd1);
  endtask

  task automatic t_reset_state;
    @(negedge clk_i);
    check("R8", result_o, 5'd0);
    check("R8", {4'b0, valid_o}, 5'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_sweep;
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply_op(2'(op), 4'(a), 4'(b));
  endtask

  task automatic t_corners;
    apply_op(2'b01, 4'h0, 4'hF);
    check("R2", {4'b0, result_o[4]}, 5'd1);
    apply_op(2'b01, 4'h7, 4'h7);
    check("R2", result_o, 5'd0);
    apply_op(2'b01, 4'hF, 4'h0);
    check("R2", {4'b0, result_o[4]}, 5'd0);
    apply_op(2'b00, 4'hF, 4'hF);
    check("R1", result_o, 5'b11110);
    apply_op(2'b10, 4'hF, 4'h3);
    check("R3", result_o, 5'b10000);
    apply_op(2'b11, 4'h9, 4'h0);
    check("R4", {3'b0, result_o[4], result_o[0]}, 5'b00010);
  endtask

  task automatic t_hold;
    logic [4:0] keep;
    apply_op(2'b00, 4'h5, 4'h6);
    keep = 5'd11;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      valid_i = 1'b0; op_i = 2'(k + 1); a_i = 4'(k + 12); b_i = 4'(k);
      @(negedge clk_i);
      check("R7", result_o, keep);
      check("R6", {4'b0, valid_o}, 5'd0);
    end
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 2'b11; a_i = 4'h3;
    @(posedge clk_i);
    #1 check("R5", result_o, 5'd6);
  endtask

  task automatic t_async_reset;
    apply_op(2'b00, 4'hA, 4'h9);
    @(negedge clk_i);
    #0.5 rst_ni = 1'b0;
    #0.5;
    check("R8", result_o, 5'd0);
    check("R8", {4'b0, valid_o}, 5'd0);
    @(negedge clk_i);
    rst_ni = 1'b1; valid_i = 1'b0;
    @(negedge clk_i);
    check("R8", result_o, 5'd0);
  endtask

  initial begin
    t_reset_state();
    t_sweep();
    t_corners();
    t_hold();
    t_async_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule